// File: doc/BRIEF.md
# Paging Control Register Flush Trigger

This block holds three paging-related control registers and turns writes to them into invalidation commands for two translation caches: one for instruction fetches and one for data accesses. Software-visible register writes come in as a select code, a data word and a write strobe. Each write to a tracked register is compared with the value already held. Depending on which register was written and which bits changed, the block sends one of two commands to both caches on the next cycle. The first drops every entry. The second drops only entries not marked global.

The three held registers are named here by their role. The mode register holds the paging-enable bit and a bit that always reads back as one. The table-root register holds the page-table base. The feature register holds the page-size, address-extension and global-page enables. Two more select codes name registers that sit beside these but never cause an invalidation, and this block does not store them. The current values of the three held registers are driven out so that the table walker can use them.

Top module: `crctl_flush`

## Requirements
- R1: A write with select code 0 (mode register) whose bit 31 (paging enable) differs from the stored bit 31 drives `flush_all` high on every cache output in the cycle after the write strobe. Index 0 is the instruction cache and index 1 is the data cache.
- R2: Every write with select code 3 (table-root register) drives `flush_ng` high on every cache output in the next cycle, even when the written value equals the stored one. The written value is stored.
- R3: A write with select code 4 (feature register) in which bit 4, 5 or 7 differs from the stored value drives `flush_all` high in the next cycle. If only other bits change, no flush is sent. The written value is stored.
- R4: The mode register stores the written value with bit 4 forced to 1, whatever was written in that bit.
- R5: Writes with select codes 2 and 8, and writes with any select code other than 0, 3 and 4, send no flush and leave all three stored registers unchanged.
- R6: Flush outputs are one-cycle pulses. In a cycle that follows a cycle with no write strobe, both flush vectors are zero.
- R7: `flush_all` and `flush_ng` are never high together. If one write qualifies for both kinds of flush, only `flush_all` is sent.
- R8: After reset the mode register reads 0x00000010, the table-root and feature registers read 0, and all flush outputs are low.
- R9: A mode-register write that leaves bit 31 unchanged sends no flush. The new value, with bit 4 forced to 1, is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 4 | Register select code (0 mode, 2 and 8 no-flush, 3 table root, 4 feature) |
| wr_data | input | 32 | Value to write |
| mode_q | output | 32 | Stored mode register |
| root_q | output | 32 | Stored table-root register |
| feat_q | output | 32 | Stored feature register |
| flush_all | output | 2 | Invalidate-all pulse per cache (bit 0 instruction, bit 1 data) |
| flush_ng | output | 2 | Invalidate-non-global pulse per cache (bit 0 instruction, bit 1 data) |

## Verification
The hardest case to reach is a write to a watched register in which only unwatched bits change. It has to produce no pulse while the stored value still moves. Reaching it needs the stored value to be known beforehand. The stimulus therefore first sets the feature and mode registers to chosen values, then flips single bits one at a time, both inside and outside the watched set. After that comes a long stretch of writes that change only a few bits at once over all select codes. Back-to-back writes are included, so that one pulse that must end meets the next one that must begin.

// File: rtl/crctl_pkg.sv
package crctl_pkg;

   localparam int unsigned SEL_W = 4;

   localparam logic [SEL_W-1:0] SEL_MODE  = 4'd0;
   localparam logic [SEL_W-1:0] SEL_FAULT = 4'd2;
   localparam logic [SEL_W-1:0] SEL_ROOT  = 4'd3;
   localparam logic [SEL_W-1:0] SEL_FEAT  = 4'd4;
   localparam logic [SEL_W-1:0] SEL_PRIO  = 4'd8;

   typedef enum logic [1:0] {
      FL_NONE      = 2'd0,
      FL_NONGLOBAL = 2'd1,
      FL_ALL       = 2'd2
   } flush_kind_e;

endpackage

// File: rtl/crctl_sel.sv
module crctl_sel
   import crctl_pkg::*;
(
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   output logic             we_mode,
   output logic             we_root,
   output logic             we_feat
);

   always_comb begin
      we_mode = 1'b0;
      we_root = 1'b0;
      we_feat = 1'b0;
      if (wr_en) begin
         unique case (wr_sel)
            SEL_MODE: we_mode = 1'b1;
            SEL_ROOT: we_root = 1'b1;
            SEL_FEAT: we_feat = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/crctl_reg.sv
module crctl_reg #(
   parameter int unsigned     DW     = 32,
   parameter logic [DW-1:0]   RST    = '0,
   parameter logic [DW-1:0]   FORCE1 = '0,
   parameter logic [DW-1:0]   WATCH  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q,
   output logic          changed
);

   localparam logic [DW-1:0] RST_EFF   = RST | FORCE1;
   localparam bit            ANY_WRITE = (WATCH == '0);

   logic [DW-1:0] q_r;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (FORCE1[b]) begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q_r[b] <= RST_EFF[b];
            else if (we) q_r[b] <= 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q_r[b] <= RST_EFF[b];
            else if (we) q_r[b] <= d[b];
         end
      end
   end

   assign q = q_r;

   if (ANY_WRITE) begin : g_any
      assign changed = we;
   end else begin : g_xor
      assign changed = we && (|((q_r ^ d) & WATCH));
   end

endmodule

// File: rtl/crctl_arb.sv
module crctl_arb
   import crctl_pkg::*;
(
   input  logic        chg_mode,
   input  logic        chg_feat,
   input  logic        chg_root,
   output flush_kind_e kind
);

   always_comb begin
      if (chg_mode || chg_feat) kind = FL_ALL;
      else if (chg_root)        kind = FL_NONGLOBAL;
      else                      kind = FL_NONE;
   end

endmodule

// File: rtl/crctl_pulse.sv
module crctl_pulse
   import crctl_pkg::*;
#(
   parameter int unsigned NTLB      = 2,
   parameter bit          REPLICATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  flush_kind_e     kind,
   output logic [NTLB-1:0] flush_all,
   output logic [NTLB-1:0] flush_ng
);

   if (REPLICATE) begin : g_rep
      for (genvar t = 0; t < NTLB; t++) begin : g_tlb
         logic all_r, ng_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               all_r <= 1'b0;
               ng_r  <= 1'b0;
            end else begin
               all_r <= (kind == FL_ALL);
               ng_r  <= (kind == FL_NONGLOBAL);
            end
         end
         assign flush_all[t] = all_r;
         assign flush_ng[t]  = ng_r;
      end
   end else begin : g_shared
      flush_kind_e kind_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) kind_r <= FL_NONE;
         else        kind_r <= kind;
      end
      assign flush_all = {NTLB{kind_r == FL_ALL}};
      assign flush_ng  = {NTLB{kind_r == FL_NONGLOBAL}};
   end

endmodule

// File: rtl/crctl_flush.sv
module crctl_flush
   import crctl_pkg::*;
#(
   parameter int unsigned   DW        = 32,
   parameter int unsigned   NTLB      = 2,
   parameter int unsigned   PG_BIT    = 31,
   parameter int unsigned   ET_BIT    = 4,
   parameter int unsigned   PSE_BIT   = 4,
   parameter int unsigned   PAE_BIT   = 5,
   parameter int unsigned   PGE_BIT   = 7,
   parameter bit            REPLICATE = 1'b1,
   parameter logic [DW-1:0] MODE_RST  = 32'h0000_0010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    mode_q,
   output logic [DW-1:0]    root_q,
   output logic [DW-1:0]    feat_q,
   output logic [NTLB-1:0]  flush_all,
   output logic [NTLB-1:0]  flush_ng
);

   localparam logic [DW-1:0] ONE        = {{(DW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] MODE_WATCH = ONE << PG_BIT;
   localparam logic [DW-1:0] MODE_FIX   = ONE << ET_BIT;
   localparam logic [DW-1:0] FEAT_WATCH = (ONE << PSE_BIT) | (ONE << PAE_BIT) | (ONE << PGE_BIT);

   if (PG_BIT >= DW || ET_BIT >= DW || PSE_BIT >= DW || PAE_BIT >= DW || PGE_BIT >= DW) begin : g_bad_bit
      $error("crctl_flush: a bit position lies outside the data width");
   end
   if (NTLB < 1) begin : g_bad_ntlb
      $error("crctl_flush: at least one cache output is needed");
   end
   if (PG_BIT == ET_BIT) begin : g_bad_mode
      $error("crctl_flush: the watched mode bit must not be the forced bit");
   end

   logic we_mode, we_root, we_feat;
   logic chg_mode, chg_root, chg_feat;
   flush_kind_e kind;

   crctl_sel u_sel (
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .we_mode (we_mode),
      .we_root (we_root),
      .we_feat (we_feat)
   );

   crctl_reg #(.DW(DW), .RST(MODE_RST), .FORCE1(MODE_FIX), .WATCH(MODE_WATCH)) u_mode (
      .clk(clk), .rst_n(rst_n), .we(we_mode), .d(wr_data), .q(mode_q), .changed(chg_mode)
   );

   crctl_reg #(.DW(DW), .RST('0), .FORCE1('0), .WATCH('0)) u_root (
      .clk(clk), .rst_n(rst_n), .we(we_root), .d(wr_data), .q(root_q), .changed(chg_root)
   );

   crctl_reg #(.DW(DW), .RST('0), .FORCE1('0), .WATCH(FEAT_WATCH)) u_feat (
      .clk(clk), .rst_n(rst_n), .we(we_feat), .d(wr_data), .q(feat_q), .changed(chg_feat)
   );

   crctl_arb u_arb (
      .chg_mode (chg_mode),
      .chg_feat (chg_feat),
      .chg_root (chg_root),
      .kind     (kind)
   );

   crctl_pulse #(.NTLB(NTLB), .REPLICATE(REPLICATE)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .flush_all (flush_all),
      .flush_ng  (flush_ng)
   );

endmodule

// File: rtl/crctl_flush_chk.sv
module crctl_flush_chk
   import crctl_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned NTLB    = 2,
   parameter int unsigned PG_BIT  = 31,
   parameter int unsigned ET_BIT  = 4,
   parameter int unsigned PSE_BIT = 4,
   parameter int unsigned PAE_BIT = 5,
   parameter int unsigned PGE_BIT = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_sel,
   input logic [DW-1:0]    wr_data,
   input logic [DW-1:0]    mode_q,
   input logic [DW-1:0]    root_q,
   input logic [DW-1:0]    feat_q,
   input logic [NTLB-1:0]  flush_all,
   input logic [NTLB-1:0]  flush_ng
);

   localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] ETM   = ONE << ET_BIT;
   localparam logic [DW-1:0] FMASK = (ONE << PSE_BIT) | (ONE << PAE_BIT) | (ONE << PGE_BIT);

   logic tracked;
   assign tracked = (wr_sel == SEL_MODE) || (wr_sel == SEL_ROOT) || (wr_sel == SEL_FEAT);

   AST_MODE_PG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_MODE && (wr_data[PG_BIT] != mode_q[PG_BIT])) |=> (&flush_all)); // R1

   AST_ROOT_ANY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_ROOT) |=> ((&flush_ng) && !(|flush_all))); // R2

   AST_FEAT_WATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_FEAT && (|((wr_data ^ feat_q) & FMASK))) |=> (&flush_all)); // R3

   AST_FEAT_UNWATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_FEAT && !(|((wr_data ^ feat_q) & FMASK))) |=> !(|flush_all) && !(|flush_ng)); // R3

   AST_MODE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_MODE) |=> (mode_q == ($past(wr_data) | ETM))); // R4

   AST_OTHER_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tracked) |=> (!(|flush_all) && !(|flush_ng) && $stable(mode_q) && $stable(root_q) && $stable(feat_q))); // R5

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!(|flush_all) && !(|flush_ng))); // R6

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !((|flush_all) && (|flush_ng))); // R7

   AST_MODE_PG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_MODE && (wr_data[PG_BIT] == mode_q[PG_BIT])) |=> !(|flush_all) && !(|flush_ng)); // R9

endmodule

bind crctl_flush crctl_flush_chk #(
   .DW(DW), .NTLB(NTLB), .PG_BIT(PG_BIT), .ET_BIT(ET_BIT),
   .PSE_BIT(PSE_BIT), .PAE_BIT(PAE_BIT), .PGE_BIT(PGE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .mode_q(mode_q), .root_q(root_q), .feat_q(feat_q),
   .flush_all(flush_all), .flush_ng(flush_ng)
);

// File: tb/sim_crctl_flush.sv
`timescale 1ns/1ps
module sim_crctl_flush;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = 4'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] mode_q, root_q, feat_q;
   logic [1:0]  flush_all, flush_ng;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;

   logic [31:0] m_mode = 32'h10;
   logic [31:0] m_root = 32'h0;
   logic [31:0] m_feat = 32'h0;
   logic        e_all = 1'b0;
   logic        e_ng  = 1'b0;
   string       e_tag = "R8";

   always #2 clk = ~clk;

   crctl_flush u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode_q(mode_q), .root_q(root_q), .feat_q(feat_q),
      .flush_all(flush_all), .flush_ng(flush_ng)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(flush_all == {2{e_all}}, e_tag, {30'd0, flush_all}, {30'd0, {2{e_all}}});
      chk(flush_ng  == {2{e_ng}},  e_tag, {30'd0, flush_ng},  {30'd0, {2{e_ng}}});
      chk(mode_q == m_mode, "R4 mode store", mode_q, m_mode);
      chk(root_q == m_root, "R2 root store", root_q, m_root);
      chk(feat_q == m_feat, "R3 feature store", feat_q, m_feat);
   endtask

   task automatic step(input logic en, input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      compare();
      wr_en = en; wr_sel = sel; wr_data = d;
      e_all = 1'b0; e_ng = 1'b0; e_tag = "R6 idle";
      if (en) begin
         case (sel)
            4'd0: begin
               if (d[31] != m_mode[31]) begin e_all = 1'b1; e_tag = "R1 paging toggle"; end
               else e_tag = "R9 mode no toggle";
               m_mode = d | 32'h10;
            end
            4'd3: begin e_ng = 1'b1; e_tag = "R2 root write"; m_root = d; end
            4'd4: begin
               if (|((d ^ m_feat) & 32'hB0)) e_all = 1'b1;
               e_tag = "R3 feature write";
               m_feat = d;
            end
            default: e_tag = "R5 other select";
         endcase
      end
   endtask

   initial begin
      #(4 * 200000);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      e_tag = "R8 reset";
      compare();
      rst_n = 1'b1;
      step(1'b0, 4'd0, 32'd0);
      step(1'b1, 4'd0, 32'h8000_0001);   // R1 set paging
      step(1'b1, 4'd0, 32'h8000_0f00);   // R9 same paging, R4 bit 4 forced
      step(1'b1, 4'd0, 32'h0000_0000);   // R1 clear paging
      step(1'b0, 4'd0, 32'd0);           // R6
      step(1'b1, 4'd3, 32'h0012_3000);   // R2
      step(1'b1, 4'd3, 32'h0012_3000);   // R2 unchanged value
      step(1'b1, 4'd4, 32'h0000_0010);   // R3 bit 4
      step(1'b1, 4'd4, 32'h0000_0030);   // R3 bit 5
      step(1'b1, 4'd4, 32'h0000_00b0);   // R3 bit 7
      step(1'b1, 4'd4, 32'h0000_00b1);   // R3 unwatched bit
      step(1'b1, 4'd4, 32'hffff_ff4f);   // R3 watched cleared, others set
      step(1'b1, 4'd2, 32'hffff_ffff);   // R5
      step(1'b1, 4'd8, 32'h8000_00b0);   // R5
      step(1'b1, 4'd1, 32'h8000_00b0);   // R5
      step(1'b1, 4'd15, 32'h8000_00b0);  // R5
      step(1'b1, 4'd3, 32'h1);           // R7 back to back
      step(1'b1, 4'd0, 32'h8000_0000);
      step(1'b1, 4'd3, 32'h2);
      step(1'b0, 4'd0, 32'd0);
      for (int i = 0; i < 2000; i++) begin
         logic [3:0]  s;
         logic [31:0] d;
         int unsigned r;
         r = $urandom_range(0, 9);
         case (r)
            0, 1, 2: s = 4'd0;
            3, 4:    s = 4'd3;
            5, 6, 7: s = 4'd4;
            8:       s = 4'd2;
            default: s = 4'd8;
         endcase
         d = (s == 4'd0) ? m_mode : (s == 4'd4) ? m_feat : $urandom;
         if ($urandom_range(0, 1) == 1) d[31] = ~d[31];
         d[$urandom_range(0, 7)] = ~d[$urandom_range(0, 7)];
         step($urandom_range(0, 4) != 0, s, d);
      end
      step(1'b0, 4'd0, 32'd0);
      step(1'b0, 4'd0, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule